// File: doc/BRIEF.md
# Global History Correlating Predictor

This block predicts the direction of conditional branches by correlating each branch with the outcomes of the branches that were resolved just before it. A shift register holds the most recent `HIST_R` outcomes. That history is combined with `IDX_B` branch address bits to pick one two-bit saturating counter from a shared table. The counter's upper bit gives the predicted direction. A build-time parameter selects how address and history are combined. Concatenation gives every address/history pair its own counter. XOR folding keeps the table at address size, and different branches then share counters.

The front end sends a branch address on the lookup stream. One cycle later it receives the predicted direction together with the history value that produced it. It carries that history with the branch down the pipe. When the branch resolves, the back end presents the same address, the carried history and the real outcome on the resolve port. The counter at the original index is trained, and the outcome is then shifted into the global history. The address bits on both ports are already stripped of instruction-alignment bits by the caller.

Back-pressure on the lookup stream works through a one-entry response register. `lk_ready` is high whenever no response is waiting or the waiting response is being taken in the same cycle. A response with `pr_valid` high and `pr_ready` low stays in place with unchanged fields. The resolve port never stalls: `rs_ready` is always high, and every cycle with `rs_valid` high is one resolved branch.

Top module: `gh_corr_predictor`

## Requirements
- R1: The history register shifts left on every resolve: the new outcome (1 = taken) enters bit 0 and the oldest bit drops out. The history does not change in any cycle without `rs_valid`.
- R2: With `MODE` = concatenation, the counter index is `{addr, hist}`, with the history in the low `HIST_R` bits. This selects one of 2^(IDX_B+HIST_R) counters.
- R3: With `MODE` = XOR, the counter index is `addr` XOR the history zero-extended to `IDX_B` bits, so the history lines up with the least significant address bits. This selects one of 2^IDX_B counters. `HIST_R` must not exceed `IDX_B`.
- R4: Counters saturate within 00..11. They increment on a taken outcome and decrement on a not-taken outcome, and hold at 11 and 00.
- R5: The prediction is taken exactly when the selected counter is 10 or 11.
- R6: A resolve trains the counter at the index formed from `rs_addr` and `rs_hist` (the history returned with the prediction), not from the live history.
- R7: Reset clears the history to zero, sets every counter to 01 and drops `pr_valid`.
- R8: A lookup accepted at a clock edge (`lk_valid && lk_ready`) raises `pr_valid` after that edge. `pr_taken` and `pr_hist` reflect the table and history as they were before that edge, including any resolve in the same cycle.
- R9: `lk_ready` is high when `pr_valid` is low or `pr_ready` is high. While `pr_valid` is high and `pr_ready` is low, `pr_taken` and `pr_hist` hold.
- R10: `rs_ready` is always high outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_addr | input | IDX_B | Branch address bits for the lookup |
| pr_valid | output | 1 | Prediction response valid |
| pr_ready | input | 1 | Consumer takes the prediction |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_hist | output | HIST_R | History used to form this prediction |
| rs_valid | input | 1 | A branch has resolved |
| rs_ready | output | 1 | Resolve accepted (always high) |
| rs_addr | input | IDX_B | Address bits of the resolved branch |
| rs_hist | input | HIST_R | History carried from its prediction |
| rs_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench drives one concatenating and one XOR-folding instance with the same stimulus and compares both against a reference model. It trains a single counter well past the top of its range and then gives it one opposite outcome. A counter that wraps instead of saturating then predicts the wrong way. It trains with a carried history that differs from the live one, so a design that indexed the update with the live history corrupts a different counter. It drives a lookup and a resolve in the same cycle, so a design that forwards the new state returns the wrong history. It also stalls the response, so a design that overwrote or dropped the waiting prediction shows up at the consumer.

// File: rtl/gh_pkg.sv
package gh_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_STT = 2'b11
  } ctr_e;

  typedef enum logic {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idx_mode_e;

  // saturating step of a two-bit direction counter
  function automatic ctr_e ctr_step(ctr_e cur, logic tk);
    ctr_e nxt;
    case (cur)
      CTR_SNT: nxt = tk ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = tk ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = tk ? CTR_STT : CTR_WNT;
      default: nxt = tk ? CTR_STT : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_taken(ctr_e c);
    return (c == CTR_WT) || (c == CTR_STT);
  endfunction

  function automatic int unsigned idx_width(idx_mode_e m, int unsigned b, int unsigned r);
    return (m == IDX_CONCAT) ? (b + r) : b;
  endfunction

endpackage

// File: rtl/gh_index_fn.sv
module gh_index_fn
  import gh_pkg::*;
#(
  parameter idx_mode_e   MODE = IDX_CONCAT,
  parameter int unsigned B    = 4,
  parameter int unsigned R    = 3,
  localparam int unsigned IW  = idx_width(MODE, B, R)
) (
  input  logic [B-1:0]  addr,
  input  logic [R-1:0]  hist,
  output logic [IW-1:0] idx
);

  generate
    if (MODE == IDX_CONCAT) begin : g_cat
      assign idx = {addr, hist};
    end else begin : g_xor
      logic [B-1:0] hist_al;
      assign hist_al = B'(hist);
      assign idx     = addr ^ hist_al;
    end
  endgenerate

endmodule

// File: rtl/gh_hist_reg.sv
module gh_hist_reg #(
  parameter int unsigned R = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [R-1:0] hist_q
);

  logic [R-1:0] hist_nxt;

  generate
    if (R == 1) begin : g_one
      assign hist_nxt = bit_in;
    end else begin : g_many
      assign hist_nxt = {hist_q[R-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
    end
  end

endmodule

// File: rtl/gh_ctr_table.sv
module gh_ctr_table
  import gh_pkg::*;
#(
  parameter int unsigned IW    = 7,
  localparam int unsigned DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_taken,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_taken
);

  ctr_e ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        ctr_q[i] <= CTR_WNT;
      end
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
    end
  end

  assign rd_taken = ctr_taken(ctr_q[rd_idx]);

endmodule

// File: rtl/gh_corr_predictor.sv
module gh_corr_predictor
  import gh_pkg::*;
#(
  parameter idx_mode_e   MODE   = IDX_CONCAT,
  parameter int unsigned IDX_B  = 4,
  parameter int unsigned HIST_R = 3,
  localparam int unsigned IW    = idx_width(MODE, IDX_B, HIST_R)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IDX_B-1:0]  lk_addr,
  output logic              pr_valid,
  input  logic              pr_ready,
  output logic              pr_taken,
  output logic [HIST_R-1:0] pr_hist,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [IDX_B-1:0]  rs_addr,
  input  logic [HIST_R-1:0] rs_hist,
  input  logic              rs_taken
);

  logic [HIST_R-1:0] hist_q;
  logic [IW-1:0]     lk_idx;
  logic [IW-1:0]     rs_idx;
  logic              lk_pred;
  logic              lk_fire;
  logic              rsp_vld_q;
  logic              rsp_tk_q;
  logic [HIST_R-1:0] rsp_hist_q;

  gh_hist_reg #(.R(HIST_R)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rs_valid),
    .bit_in   (rs_taken),
    .hist_q   (hist_q)
  );

  // lookup index uses the live history, resolve uses the carried one
  gh_index_fn #(.MODE(MODE), .B(IDX_B), .R(HIST_R)) u_lk_idx (
    .addr (lk_addr),
    .hist (hist_q),
    .idx  (lk_idx)
  );

  gh_index_fn #(.MODE(MODE), .B(IDX_B), .R(HIST_R)) u_rs_idx (
    .addr (rs_addr),
    .hist (rs_hist),
    .idx  (rs_idx)
  );

  gh_ctr_table #(.IW(IW)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_idx),
    .rd_taken (lk_pred),
    .wr_en    (rs_valid),
    .wr_idx   (rs_idx),
    .wr_taken (rs_taken)
  );

  assign lk_ready = !rsp_vld_q || pr_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign rs_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_q  <= 1'b0;
      rsp_tk_q   <= 1'b0;
      rsp_hist_q <= '0;
    end else if (lk_fire) begin
      rsp_vld_q  <= 1'b1;
      rsp_tk_q   <= lk_pred;
      rsp_hist_q <= hist_q;
    end else if (pr_ready) begin
      rsp_vld_q  <= 1'b0;
    end
  end

  assign pr_valid = rsp_vld_q;
  assign pr_taken = rsp_tk_q;
  assign pr_hist  = rsp_hist_q;

endmodule

// File: rtl/gh_corr_predictor_chk.sv
module gh_corr_predictor_chk #(
  parameter int unsigned R = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         lk_valid,
  input logic         lk_ready,
  input logic         pr_valid,
  input logic         pr_ready,
  input logic         pr_taken,
  input logic [R-1:0] pr_hist,
  input logic         rs_valid,
  input logic         rs_taken,
  input logic [R-1:0] hist_q
);

  a_r1_hist_shift: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> hist_q == R'({$past(hist_q), $past(rs_taken)}));

  a_r1_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> $stable(hist_q));

  a_r7_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hist_q == '0) && !pr_valid);

  a_r8_resp_after_accept: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_ready |=> pr_valid && (pr_hist == $past(hist_q)));

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_taken) && $stable(pr_hist));

  a_r9_idle_ready: assert property (@(posedge clk) disable iff (rst)
    !pr_valid |-> lk_ready);

endmodule

bind gh_corr_predictor gh_corr_predictor_chk #(.R(HIST_R)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .pr_valid (pr_valid),
  .pr_ready (pr_ready),
  .pr_taken (pr_taken),
  .pr_hist  (pr_hist),
  .rs_valid (rs_valid),
  .rs_taken (rs_taken),
  .hist_q   (hist_q)
);

// File: tb/gh_corr_predictor_tb_top.sv
`timescale 1ns/1ps
module gh_corr_predictor_tb_top;
  import gh_pkg::*;

  localparam int CLK_P = 10;
  localparam int B = 4;
  localparam int R = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [B-1:0] lk_addr = '0;
  logic pr_ready = 1'b1;
  logic rs_valid = 1'b0;
  logic [B-1:0] rs_addr = '0;
  logic [R-1:0] rs_hist = '0;
  logic rs_taken = 1'b0;

  logic c_lk_ready, c_pr_valid, c_pr_taken, c_rs_ready;
  logic [R-1:0] c_pr_hist;
  logic x_lk_ready, x_pr_valid, x_pr_taken, x_rs_ready;
  logic [R-1:0] x_pr_hist;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  gh_corr_predictor #(.MODE(IDX_CONCAT), .IDX_B(B), .HIST_R(R)) dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(c_lk_ready), .lk_addr(lk_addr),
    .pr_valid(c_pr_valid), .pr_ready(pr_ready), .pr_taken(c_pr_taken), .pr_hist(c_pr_hist),
    .rs_valid(rs_valid), .rs_ready(c_rs_ready), .rs_addr(rs_addr), .rs_hist(rs_hist),
    .rs_taken(rs_taken));

  gh_corr_predictor #(.MODE(IDX_XOR), .IDX_B(B), .HIST_R(R)) dut_x (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(x_lk_ready), .lk_addr(lk_addr),
    .pr_valid(x_pr_valid), .pr_ready(pr_ready), .pr_taken(x_pr_taken), .pr_hist(x_pr_hist),
    .rs_valid(rs_valid), .rs_ready(x_rs_ready), .rs_addr(rs_addr), .rs_hist(rs_hist),
    .rs_taken(rs_taken));

  // reference model
  int m_cat [128];
  int m_xor [16];
  logic [R-1:0] m_hist;

  // scoreboard queues: {taken, hist}
  logic [R:0] q_cat [$];
  logic [R:0] q_xor [$];
  string q_tag [$];
  string q_tagx [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ix_cat(logic [B-1:0] a, logic [R-1:0] h);
    return int'({a, h});
  endfunction

  function automatic int ix_xor(logic [B-1:0] a, logic [R-1:0] h);
    return int'(a ^ {1'b0, h});
  endfunction

  function automatic void model_reset();
    foreach (m_cat[i]) m_cat[i] = 1;
    foreach (m_xor[i]) m_xor[i] = 1;
    m_hist = '0;
  endfunction

  function automatic int sat(int v, logic t);
    if (t) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic void model_train(logic [B-1:0] a, logic [R-1:0] h, logic t);
    m_cat[ix_cat(a, h)] = sat(m_cat[ix_cat(a, h)], t);
    m_xor[ix_xor(a, h)] = sat(m_xor[ix_xor(a, h)], t);
    m_hist = {m_hist[R-2:0], t};
  endfunction

  function automatic void push_expect(logic [B-1:0] a, string tag);
    logic pc;
    logic px;
    pc = (m_cat[ix_cat(a, m_hist)] >= 2);
    px = (m_xor[ix_xor(a, m_hist)] >= 2);
    q_cat.push_back({pc, m_hist});
    q_xor.push_back({px, m_hist});
    q_tag.push_back(tag);
    q_tagx.push_back(tag);
  endfunction

  // monitor: samples three quarters into the cycle, before the transfer edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (!rst) begin
        if (c_pr_valid && pr_ready) begin
          if (q_cat.size() == 0) check(1'b0, "R8", "concat unexpected response", 1, 0);
          else begin
            logic [R:0] e;
            string t;
            e = q_cat.pop_front();
            t = q_tag.pop_front();
            check({c_pr_taken, c_pr_hist} == e, t, "concat {taken,hist}",
                  int'({c_pr_taken, c_pr_hist}), int'(e));
          end
        end
        if (x_pr_valid && pr_ready) begin
          if (q_xor.size() == 0) check(1'b0, "R8", "xor unexpected response", 1, 0);
          else begin
            logic [R:0] e;
            string t;
            e = q_xor.pop_front();
            t = q_tagx.pop_front();
            check({x_pr_taken, x_pr_hist} == e, t, "xor {taken,hist}",
                  int'({x_pr_taken, x_pr_hist}), int'(e));
          end
        end
      end
    end
  end

  task automatic do_lookup(input logic [B-1:0] a, input string tag, output logic [R-1:0] h_used);
    int n;
    @(negedge clk);
    #1;
    lk_valid = 1'b1;
    lk_addr  = a;
    #1;
    n = 0;
    while (!c_lk_ready) begin
      @(negedge clk);
      n++;
      if (n > 2) pr_ready = 1'b1;
      #1;
    end
    h_used = m_hist;
    push_expect(a, tag);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_resolve(input logic [B-1:0] a, input logic [R-1:0] h, input logic t);
    @(negedge clk);
    rs_valid = 1'b1;
    rs_addr  = a;
    rs_hist  = h;
    rs_taken = t;
    model_train(a, h, t);
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  logic [R-1:0] hu;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 / R9 / R10: idle state after reset
    check(c_pr_valid == 1'b0 && x_pr_valid == 1'b0, "R7", "pr_valid after reset", int'(c_pr_valid), 0);
    check(c_lk_ready == 1'b1, "R9", "lk_ready when idle", int'(c_lk_ready), 1);
    check(c_rs_ready && x_rs_ready, "R10", "rs_ready high", int'(c_rs_ready), 1);

    // R7 / R5: untrained counters are 01, predict not-taken with zero history
    do_lookup(4'd0, "R7", hu);
    do_lookup(4'd5, "R7", hu);
    do_lookup(4'd15, "R5", hu);

    // R4: saturate one counter high, then one not-taken leaves it at 10
    for (int i = 0; i < 5; i++) do_resolve(4'd9, 3'b110, 1'b1);
    do_resolve(4'd9, 3'b110, 1'b0);
    check(m_hist == 3'b110, "R1", "bench history bookkeeping", int'(m_hist), 6);
    do_lookup(4'd9, "R4", hu);
    // R4: drive it to the floor and one step back up
    for (int i = 0; i < 4; i++) do_resolve(4'd9, 3'b110, 1'b0);
    do_resolve(4'd9, 3'b110, 1'b1);
    do_lookup(4'd9, "R4", hu);

    // R1 R2 R3 R6: alternating branch, trained with the carried history
    for (int i = 0; i < 16; i++) begin
      do_lookup(4'd3, "R6", hu);
      do_resolve(4'd3, hu, logic'(i % 2));
    end
    // R2 R3: two addresses that collide only in the XOR table
    for (int i = 0; i < 6; i++) begin
      do_lookup(4'd10, "R2", hu);
      do_resolve(4'd10, hu, 1'b1);
      do_lookup(4'd12, "R3", hu);
      do_resolve(4'd12, hu, 1'b0);
    end

    // R8: lookup and resolve in the same cycle see pre-update state
    @(negedge clk);
    pr_ready = 1'b1;
    #1;
    lk_valid = 1'b1;
    lk_addr  = 4'd7;
    rs_valid = 1'b1;
    rs_addr  = 4'd7;
    rs_hist  = m_hist;
    rs_taken = 1'b1;
    check(c_lk_ready == 1'b1, "R9", "lk_ready with consumer ready", int'(c_lk_ready), 1);
    push_expect(4'd7, "R8");
    model_train(4'd7, rs_hist, 1'b1);
    @(negedge clk);
    lk_valid = 1'b0;
    rs_valid = 1'b0;

    // R9: stall the response, second lookup must wait
    @(negedge clk);
    pr_ready = 1'b0;
    do_lookup(4'd2, "R9", hu);
    #1;
    lk_valid = 1'b1;
    lk_addr  = 4'd11;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(c_lk_ready == 1'b0, "R9", "lk_ready while stalled", int'(c_lk_ready), 0);
      check(c_pr_valid == 1'b1, "R9", "pr_valid held while stalled", int'(c_pr_valid), 1);
      @(negedge clk);
    end
    pr_ready = 1'b1;
    push_expect(4'd11, "R9");
    @(negedge clk);
    lk_valid = 1'b0;

    // mixed traffic with random back-pressure
    for (int i = 0; i < 400; i++) begin
      logic [B-1:0] a;
      logic t;
      a = B'($urandom_range(0, 15));
      t = (a[0] ^ m_hist[1]) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 9) < 2);
      @(negedge clk);
      pr_ready = ($urandom_range(0, 3) != 0);
      do_lookup(a, "R6", hu);
      do_resolve(a, hu, t);
    end

    pr_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(q_cat.size() == 0 && q_xor.size() == 0, "R8", "responses outstanding",
          q_cat.size() + q_xor.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule